// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each run on their own clock. A word is accepted on a rising write-clock edge only when both active-low write enables are low and the buffer is not full. A word is delivered on a rising read-clock edge only when both active-low read enables are low and the buffer is not empty. The read data output is registered. It holds its value between accepted reads.

The block reports four active-low status flags. Empty and almost-empty belong to the read clock domain. Full and almost-full belong to the write clock domain. The almost-empty and almost-full thresholds arrive as runtime inputs from a companion register block. Each domain sees the other side's pointer only as a Gray-coded value that has passed through a synchronizer chain. Each flag is then registered in a single flip-flop in the domain that updates it. The depth is a power of two set by the address-width parameter.

Top module: `dcfifo_prog_flags`

## Requirements
- R1: Every word is 9 bits wide, and words leave the read port in the order in which they were accepted.
- R2: `full_n` is low whenever the buffer holds exactly DEPTH unread words. It changes only on rising edges of `clk_w`, and it rises again once a read has become visible to the write side.
- R3: A write is accepted only when `wen1_n` and `wen2_n` are both low and `full_n` is high. Any other write attempt leaves the buffer contents unchanged.
- R4: `empty_n` is low whenever no unread word is present, and it changes only on rising edges of `clk_r`. It falls on the same read edge that takes the last word.
- R5: A read is accepted only when `ren1_n` and `ren2_n` are both low and `empty_n` is high. Otherwise `dout` keeps its value and no word is consumed.
- R6: `ae_n` is low when `ae_level` or fewer unread words are present. It is high when `ae_level`+1 or more are present, and it is updated on rising edges of `clk_r`.
- R7: `af_n` is low when DEPTH−`af_level` or more words are unread. It is high when more than `af_level` locations are free, and it is updated on rising edges of `clk_w`.
- R8: After `rst` (active-high, synchronous in each domain), the outputs are `empty_n`=0, `full_n`=1, `ae_n`=0, `af_n`=1 and `dout`=0.
- R9: The read data is registered. The word appears on `dout` after the `clk_r` edge that accepts the read, and not before it.
- R10: Pointers cross between domains as Gray code through a two-stage synchronizer, and they change by at most one bit per source clock. A freshly written word therefore cannot clear `empty_n` at the first read edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, sampled synchronously in each domain |
| wen1_n | input | 1 | Write enable, active low |
| wen2_n | input | 1 | Second write enable, active low |
| din | input | 9 | Write data |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| ae_level | input | ADDR_W | Almost-empty threshold n |
| af_level | input | ADDR_W | Almost-full threshold m (free locations) |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions take four things for granted about the inputs:
- `rst` is held for several edges of both clocks, so that both domains and every synchronizer stage start cleared.
- The threshold inputs are quasi-static.
- The clocks keep running during reset.
- The inputs never change on the edge of the clock that samples them.

The stimulus keeps within these limits. It drives write-side inputs on falling edges of `clk_w` and read-side inputs on falling edges of `clk_r`. It changes `ae_level` and `af_level` only while no transfer is in progress. It waits out the synchronizer latency before it checks any flag that depends on the other domain's pointer.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // One write beat handed from the control path to the storage array.
    typedef struct packed {
        logic  en;
        word_t data;
    } wr_beat_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W:0]   rptr_gray_s,
    input  logic [ADDR_W-1:0] af_level,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wptr_gray,
    output logic              full_n,
    output logic              af_n
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx, af_limit;

    assign wr_ok    = wr_req & full_n;
    assign wbin_nx  = wbin + PW'(wr_ok);
    assign rbin_s   = PW'(gray_to_bin(32'(rptr_gray_s)));
    assign used_nx  = wbin_nx - rbin_s;
    assign af_limit = PW'(DEPTH) - {1'b0, af_level};
    assign waddr    = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin      <= '0;
            wptr_gray <= '0;
            full_n    <= 1'b1;
            af_n      <= 1'b1;
        end else begin
            wbin      <= wbin_nx;
            wptr_gray <= PW'(bin_to_gray(32'(wbin_nx)));
            full_n    <= (used_nx != PW'(DEPTH));
            af_n      <= (used_nx < af_limit);
        end
    end

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_req) |=> $stable(wbin)); // R3
    AST_USED_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin - rbin_s) <= PW'(DEPTH))); // R2
    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !af_n); // R7
    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R10

endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W:0]   wptr_gray_s,
    input  logic [ADDR_W-1:0] ae_level,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic              empty_n,
    output logic              ae_n
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, avail_nx;

    assign rd_ok    = rd_req & empty_n;
    assign rbin_nx  = rbin + PW'(rd_ok);
    assign wbin_s   = PW'(gray_to_bin(32'(wptr_gray_s)));
    assign avail_nx = wbin_s - rbin_nx;
    assign raddr    = rbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rptr_gray <= '0;
            empty_n   <= 1'b0;
            ae_n      <= 1'b0;
        end else begin
            rbin      <= rbin_nx;
            rptr_gray <= PW'(bin_to_gray(32'(rbin_nx)));
            empty_n   <= (avail_nx != '0);
            ae_n      <= (avail_nx > {1'b0, ae_level});
        end
    end

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !empty_n |=> $stable(rbin)); // R5
    AST_AVAIL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin_s - rbin) <= PW'(DEPTH))); // R4
    AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !ae_n); // R6
    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rptr_gray ^ $past(rptr_gray)) <= 1); // R10

endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk_w,
    input  wr_beat_t          wbeat,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              clk_r,
    input  logic              rst,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             dout
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk_w) begin
        if (wbeat.en) begin
            mem[waddr] <= wbeat.data;
        end
    end

    always_ff @(posedge clk_r) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_ok) begin
            dout <= mem[raddr];
        end
    end

    AST_DOUT_HOLDS: assert property (@(posedge clk_r) disable iff (rst)
        !rd_ok |=> $stable(dout)); // R5

endmodule

// File: rtl/dcfifo_prog_flags.sv
module dcfifo_prog_flags
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              clk_r,
    input  logic              rst,
    input  logic              wen1_n,
    input  logic              wen2_n,
    input  logic [8:0]        din,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [ADDR_W-1:0] ae_level,
    input  logic [ADDR_W-1:0] af_level,
    output logic [8:0]        dout,
    output logic              empty_n,
    output logic              full_n,
    output logic              ae_n,
    output logic              af_n
);

    localparam int PW = ADDR_W + 1;

    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
    wr_beat_t          wbeat;

    assign wbeat = '{en: wr_ok, data: din};

    dcfifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk_w),
        .rst        (rst),
        .wr_req     (!wen1_n && !wen2_n),
        .rptr_gray_s(rptr_gray_s),
        .af_level   (af_level),
        .wr_ok      (wr_ok),
        .waddr      (waddr),
        .wptr_gray  (wptr_gray),
        .full_n     (full_n),
        .af_n       (af_n)
    );

    dcfifo_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk_r),
        .rst        (rst),
        .rd_req     (!ren1_n && !ren2_n),
        .wptr_gray_s(wptr_gray_s),
        .ae_level   (ae_level),
        .rd_ok      (rd_ok),
        .raddr      (raddr),
        .rptr_gray  (rptr_gray),
        .empty_n    (empty_n),
        .ae_n       (ae_n)
    );

    dcfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(clk_r), .rst(rst), .d(wptr_gray), .q(wptr_gray_s)
    );

    dcfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(clk_w), .rst(rst), .d(rptr_gray), .q(rptr_gray_s)
    );

    dcfifo_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk_w(clk_w),
        .wbeat(wbeat),
        .waddr(waddr),
        .clk_r(clk_r),
        .rst  (rst),
        .rd_ok(rd_ok),
        .raddr(raddr),
        .dout (dout)
    );

endmodule

// File: tb/sim_dcfifo_prog_flags.sv
`timescale 1ns/1ps
module sim_dcfifo_prog_flags;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk_w = 1'b0, clk_r = 1'b0, rst = 1'b1;
    logic wen1_n = 1'b1, wen2_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [8:0] din = '0;
    logic [ADDR_W-1:0] ae_level = 4'd2, af_level = 4'd3;
    logic [8:0] dout;
    logic empty_n, full_n, ae_n, af_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [8:0] model [$];

    always #2 clk_w = ~clk_w;   // 250 MHz
    always #3 clk_r = ~clk_r;

    dcfifo_prog_flags #(.ADDR_W(ADDR_W)) u0 (
        .clk_w(clk_w), .clk_r(clk_r), .rst(rst),
        .wen1_n(wen1_n), .wen2_n(wen2_n), .din(din),
        .ren1_n(ren1_n), .ren2_n(ren2_n),
        .ae_level(ae_level), .af_level(af_level),
        .dout(dout), .empty_n(empty_n), .full_n(full_n),
        .ae_n(ae_n), .af_n(af_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk_r);
        repeat (6) @(negedge clk_w);
    endtask

    task automatic push(input logic [8:0] v, input logic e1, input logic e2);
        @(negedge clk_w);
        wen1_n = e1; wen2_n = e2; din = v;
        @(negedge clk_w);
        wen1_n = 1'b1; wen2_n = 1'b1;
        if (!e1 && !e2 && model.size() < DEPTH) model.push_back(v);
    endtask

    task automatic pop(input logic e1, input logic e2, output logic [8:0] v);
        @(negedge clk_r);
        ren1_n = e1; ren2_n = e2;
        @(negedge clk_r);
        ren1_n = 1'b1; ren2_n = 1'b1;
        v = dout;
    endtask

    task automatic pop_expect(input string tag);
        logic [8:0] v, e;
        e = model.pop_front();
        pop(1'b0, 1'b0, v);
        check(tag, v, e);
    endtask

    task automatic t_reset();
        check("R8 empty_n", empty_n, 0);
        check("R8 full_n", full_n, 1);
        check("R8 ae_n", ae_n, 0);
        check("R8 af_n", af_n, 1);
        check("R8 dout", dout, 0);
    endtask

    task automatic t_single();
        @(negedge clk_w);
        wen1_n = 1'b0; wen2_n = 1'b0; din = 9'h1A5;
        @(posedge clk_w);
        #0.5;
        wen1_n = 1'b1; wen2_n = 1'b1;
        model.push_back(9'h1A5);
        check("R10 empty still low after write", empty_n, 0);
        @(posedge clk_r);
        #0.5;
        check("R10 empty low at first read edge", empty_n, 0);
        settle();
        check("R4 empty_n high with one word", empty_n, 1);
        check("R6 ae_n low with 1 word", ae_n, 0);
        @(negedge clk_r);
        ren1_n = 1'b0; ren2_n = 1'b0;
        #0.5;
        check("R9 dout before read edge", dout, 0);
        @(negedge clk_r);
        ren1_n = 1'b1; ren2_n = 1'b1;
        check("R9/R1 dout after read edge", dout, model.pop_front());
        check("R4 empty_n low after last read", empty_n, 0);
    endtask

    task automatic t_enables();
        logic [8:0] v;
        push(9'h0F0, 1'b0, 1'b1);
        push(9'h0F1, 1'b1, 1'b0);
        settle();
        check("R3 single write enable ignored", empty_n, 0);
        for (int i = 0; i < 3; i++) push(9'h120 + 9'(i), 1'b0, 1'b0);
        settle();
        check("R6 ae_n high with 3 words", ae_n, 1);
        pop(1'b0, 1'b1, v);
        check("R5 single read enable holds dout", v, 9'h1A5);
        check("R5 single read enable consumes nothing", ae_n, 1);
        pop_expect("R1 order word0");
        check("R6 ae_n low at n words", ae_n, 0);
        pop_expect("R1 order word1");
        pop_expect("R1 order word2");
        check("R4 empty after drain", empty_n, 0);
        pop(1'b0, 1'b0, v);
        check("R5 read when empty holds dout", v, 9'h122);
    endtask

    task automatic t_fill();
        logic [8:0] v;
        for (int i = 0; i < DEPTH - 4; i++) push(9'h040 + 9'(i), 1'b0, 1'b0);
        settle();
        check("R7 af_n high with m+1 free", af_n, 1);
        check("R2 not full", full_n, 1);
        push(9'h040 + 9'(DEPTH - 4), 1'b0, 1'b0);
        check("R7 af_n low with m free", af_n, 0);
        for (int i = DEPTH - 3; i < DEPTH; i++) push(9'h040 + 9'(i), 1'b0, 1'b0);
        check("R2 full_n low at depth", full_n, 0);
        push(9'h1FF, 1'b0, 1'b0);
        settle();
        check("R2 still full after blocked write", full_n, 0);
        check("R6 ae_n high when full", ae_n, 1);
        pop_expect("R1 first word from full buffer");
        settle();
        check("R2 full_n high after one read", full_n, 1);
        check("R7 af_n low with one free", af_n, 0);
        while (model.size() > 0) pop_expect("R3 order, blocked word absent");
        check("R4 empty after full drain", empty_n, 0);
        pop(1'b0, 1'b0, v);
        check("R3 overflow word never stored", v, 9'h040 + 9'(DEPTH - 1));
        settle();
        check("R7 af_n high after drain", af_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk_w);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk_r);
        @(negedge clk_w);
        rst = 1'b0;
        @(negedge clk_w);
        t_reset();
        t_single();
        t_enables();
        t_fill();
        report();
    end

endmodule